// File: doc/BRIEF.md
# Serial Transmitter with Framing, Break and Pause Control

This block turns bytes into asynchronous serial frames on a single output line. A byte is handed over on a valid/ready pair. The bit rate comes from a one-cycle strobe made by an external rate generator, and each strobe advances the line by one bit. A byte-wide configuration write port sets the frame shape. That shape covers the data length, the parity kind and the number of stop bits. The same port controls a transmit enable, a break condition that pins the line low, and a flow-control mode.

Flow control can pause the start of new frames in two ways. In the first, the transmitter waits on an active-low clear-to-send input. In the second, it watches bytes reported by an external receiver. One programmable byte value stops the transmitter and another lets it continue. In every case a frame that has already started runs to its last stop bit. The flow mode can only be changed while both enable bits are clear, so the pause rules never change under a live link.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset `txd` is high, `in_ready` is low, break is off, the flow mode is none and both enable bits are clear.
- R2: A frame is one low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. Format register 0x0b bits [3:0] = 7 selects 7 data bits and 8 selects 8. Bit 7 set selects two stop bits. The line is high whenever no frame or break is being driven.
- R3: Format bits [6:4] choose the parity bit: 0 none, 1 odd (the data bits plus parity hold an odd count of ones), 2 even, 3 mark (always 1), 4 space (always 0).
- R4: A length field other than 7 or 8 gives 8 data bits. A parity field of 5, 6 or 7 gives no parity.
- R5: Bit 0 of the enable register 0x03 is the transmit enable. While it is clear, `in_ready` is low and no byte is accepted.
- R6: Writing 0xff to register 0x14 turns break on, which holds `txd` low and `in_ready` low. Writing 0x00 turns break off. Any other value leaves the break state unchanged.
- R7: A break turned on during a frame does not cut the frame. Every bit of the frame is sent, and the line goes low after the last stop bit.
- R8: Register 0x0c sets the flow mode: 0 none (`cts_n` and received bytes have no effect), 1 hardware, 2 software. A write of any other value is ignored.
- R9: In hardware mode a byte is accepted only while `cts_n` is low. A frame in progress completes when `cts_n` goes high.
- R10: In software mode, a `rx_valid` byte equal to the stop character (register 0x11) pauses acceptance of new bytes. A byte equal to the resume character (register 0x10) ends the pause. Other bytes change nothing, and a frame in progress completes.
- R11: A write to register 0x0c while enable bit 0 or bit 1 is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Transmit byte valid |
| in_data | input | 8 | Transmit byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| cts_n | input | 1 | Active-low clear-to-send |
| rx_valid | input | 1 | Received byte valid from the external receiver |
| rx_data | input | 8 | Received byte |
| txd | output | 1 | Serial output line |

## Verification
The hardest situations to reach are a control change that arrives between the start of a frame and its end. These are a break being switched on, `cts_n` rising, or the stop character arriving. The correct response is to ignore the change until the frame ends and only then act on it. The bench reaches these situations by completing the handshake and then applying the change before the first bit strobe. It then strobes the frame out bit by bit and compares the full bit pattern. Afterwards it checks that the line is held low, or that `in_ready` stays low, as the change requires.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic [7:0] ADDR_ENABLE = 8'h03;
  localparam logic [7:0] ADDR_FORMAT = 8'h0b;
  localparam logic [7:0] ADDR_FLOW   = 8'h0c;
  localparam logic [7:0] ADDR_RESUME = 8'h10;
  localparam logic [7:0] ADDR_STOP   = 8'h11;
  localparam logic [7:0] ADDR_BREAK  = 8'h14;

  typedef enum logic [1:0] {
    FLOW_NONE = 2'd0,
    FLOW_HW   = 2'd1,
    FLOW_SW   = 2'd2
  } flow_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_e;

  typedef struct packed {
    logic full_len;   // 1: full byte width, 0: one bit shorter
    par_e par;
    logic two_stop;
  } fmt_t;
endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic              tx_en,
  output logic              rx_en,
  output fmt_t              fmt,
  output flow_e             flow,
  output logic [DATA_W-1:0] resume_ch,
  output logic [DATA_W-1:0] stop_ch,
  output logic              brk_on,
  output logic              flow_wr
);
  localparam logic [3:0] LEN_SHORT = 4'(DATA_W - 1);

  logic flow_ok;
  assign flow_ok = we && (addr == ADDR_FLOW) && !tx_en && !rx_en &&
                   (wdata <= REG_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      fmt       <= '{full_len: 1'b1, par: PAR_NONE, two_stop: 1'b0};
      flow      <= FLOW_NONE;
      resume_ch <= '0;
      stop_ch   <= '0;
      brk_on    <= 1'b0;
      flow_wr   <= 1'b0;
    end else begin
      flow_wr <= flow_ok;
      if (flow_ok) flow <= flow_e'(wdata[1:0]);
      if (we) begin
        case (addr)
          ADDR_ENABLE: begin
            tx_en <= wdata[0];
            rx_en <= wdata[1];
          end
          ADDR_FORMAT: begin
            fmt.full_len <= (wdata[3:0] != LEN_SHORT);
            fmt.par      <= (wdata[6:4] <= 3'd4) ? par_e'(wdata[6:4]) : PAR_NONE;
            fmt.two_stop <= wdata[7];
          end
          ADDR_RESUME: resume_ch <= DATA_W'(wdata);
          ADDR_STOP:   stop_ch   <= DATA_W'(wdata);
          ADDR_BREAK: begin
            if (wdata == '1)      brk_on <= 1'b1;
            else if (wdata == '0) brk_on <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_gate.sv
module uart_tx_gate
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  flow_e             flow,
  input  logic              flow_wr,
  input  logic [DATA_W-1:0] resume_ch,
  input  logic [DATA_W-1:0] stop_ch,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cts_n,
  input  logic              tx_en,
  input  logic              brk_on,
  output logic              paused,
  output logic              can_start
);
  always_ff @(posedge clk) begin
    if (rst || flow_wr) begin
      paused <= 1'b0;
    end else if (rx_valid && flow == FLOW_SW) begin
      if (rx_data == stop_ch)        paused <= 1'b1;
      else if (rx_data == resume_ch) paused <= 1'b0;
    end
  end

  always_comb begin
    can_start = tx_en && !brk_on;
    if (flow == FLOW_HW && cts_n)  can_start = 1'b0;
    if (flow == FLOW_SW && paused) can_start = 1'b0;
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  fmt_t              fmt,
  output logic              busy,
  output logic              bit_q
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame, sh;
  logic [CNT_W-1:0]   nbits, cnt;
  logic [DATA_W-1:0]  d;
  logic               par_bit, has_par;
  int                 ndata;

  always_comb begin
    ndata = fmt.full_len ? DATA_W : DATA_W - 1;
    d = data;
    if (!fmt.full_len) d[DATA_W-1] = 1'b0;
    has_par = (fmt.par != PAR_NONE);
    case (fmt.par)
      PAR_ODD:  par_bit = ~^d;
      PAR_EVEN: par_bit = ^d;
      PAR_MARK: par_bit = 1'b1;
      default:  par_bit = 1'b0;
    endcase
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < ndata) frame[i+1] = d[i];
    end
    if (has_par) frame[ndata+1] = par_bit;
    nbits = CNT_W'(2 + ndata + int'(has_par) + int'(fmt.two_stop));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      bit_q <= 1'b1;
      sh    <= '1;
      cnt   <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sh   <= frame;
      cnt  <= nbits;
    end else if (busy && baud_tick) begin
      if (cnt != '0) begin
        bit_q <= sh[0];
        sh    <= {1'b1, sh[FRAME_W-1:1]};
        cnt   <= cnt - 1'b1;
      end else begin
        busy  <= 1'b0;
        bit_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              baud_tick,
  input  logic              cts_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              txd
);
  logic              tx_en, rx_en, brk_on, flow_wr, paused, can_start, busy, bit_q;
  fmt_t              fmt;
  flow_e             flow_mode;
  logic [DATA_W-1:0] resume_ch, stop_ch;

  uart_tx_regs #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tx_en(tx_en), .rx_en(rx_en), .fmt(fmt), .flow(flow_mode),
    .resume_ch(resume_ch), .stop_ch(stop_ch), .brk_on(brk_on), .flow_wr(flow_wr)
  );

  uart_tx_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst), .flow(flow_mode), .flow_wr(flow_wr),
    .resume_ch(resume_ch), .stop_ch(stop_ch), .rx_valid(rx_valid),
    .rx_data(rx_data), .cts_n(cts_n), .tx_en(tx_en), .brk_on(brk_on),
    .paused(paused), .can_start(can_start)
  );

  assign in_ready = !busy && can_start;

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .load(in_valid && in_ready),
    .data(in_data), .fmt(fmt), .busy(busy), .bit_q(bit_q)
  );

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= busy ? bit_q : !brk_on;
  end
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       cts_n,
  input logic       txd,
  input logic       tx_en,
  input logic       rx_en,
  input logic       brk_on,
  input logic       busy,
  input logic       paused,
  input logic [1:0] flow_mode
);
  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_en);                                            // R5
  AST_BREAK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    brk_on |-> !in_ready);                                          // R6
  AST_HW_WAITS_CTS: assert property (@(posedge clk) disable iff (rst)
    (in_ready && flow_mode == 2'd1) |-> !cts_n);                    // R9
  AST_SW_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_ready && flow_mode == 2'd2) |-> !paused);                   // R10
  AST_FLOW_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (tx_en || rx_en) |=> $stable(flow_mode));                       // R11
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!busy && !brk_on && $past(!busy && !brk_on)) |-> txd);         // R2
endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .cts_n(cts_n), .txd(txd),
  .tx_en(tx_en), .rx_en(rx_en), .brk_on(brk_on), .busy(busy),
  .paused(paused), .flow_mode(flow_mode)
);

// File: tb/tb_uart_tx_flow.sv
`timescale 1ns/1ps
module tb_uart_tx_flow;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic baud_tick = 1'b0, cts_n = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic txd;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_tx_flow dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .baud_tick(baud_tick), .cts_n(cts_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .txd(txd)
  );

  // {format, byte, expected bits in send order from bit 0, bit count}
  localparam logic [31:0] VEC [8] = '{
    32'h08_A5_34A_A,   // R2 8N1
    32'h18_03_606_B,   // R3 odd
    32'hA8_07_E0E_C,   // R2 R3 even, two stops
    32'h37_FF_3FE_A,   // R3 mark, 7 bits
    32'h47_81_202_A,   // R3 space, 7 bits
    32'h0F_3C_278_A,   // R4 bad length
    32'h78_81_302_A,   // R4 bad parity
    32'h27_80_200_A    // R2 R3 7 bits drops top bit
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    for (int w = 0; w < 50 && !in_ready; w++) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick_sample(output logic b);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    @(negedge clk);
    b = txd;
    @(negedge clk);
  endtask

  task automatic capture(input int n, output logic [11:0] bits);
    logic b;
    bits = '0;
    for (int i = 0; i < n; i++) begin
      tick_sample(b);
      bits[i] = b;
    end
    tick_sample(b);   // closes the last stop bit
  endtask

  initial begin
    logic [11:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd after reset", txd, 1);
    chk(in_ready == 1'b0, "R1 ready after reset", in_ready, 0);
    in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R5 disabled blocks", in_ready, 0);
    in_valid = 1'b0;
    wr(8'h03, 8'h01);
    chk(in_ready == 1'b1, "R5 enable allows, R8 mode none ignores cts_n", in_ready, 1);

    for (int v = 0; v < 8; v++) begin
      wr(8'h0b, VEC[v][31:24]);
      send(VEC[v][23:16]);
      capture(int'(VEC[v][3:0]), got);
      chk(got == VEC[v][15:4], "R2/R3/R4 frame bits", got, VEC[v][15:4]);
      chk(txd == 1'b1, "R2 idle high after frame", txd, 1);
    end

    wr(8'h0b, 8'h08);
    wr(8'h03, 8'h00);
    chk(in_ready == 1'b0, "R5 disable", in_ready, 0);
    wr(8'h03, 8'h01);
    wr(8'h14, 8'hff);
    @(negedge clk);
    chk(txd == 1'b0, "R6 break low", txd, 0);
    chk(in_ready == 1'b0, "R6 break blocks", in_ready, 0);
    wr(8'h14, 8'h55);
    @(negedge clk);
    chk(txd == 1'b0, "R6 other value ignored", txd, 0);
    wr(8'h14, 8'h00);
    @(negedge clk);
    chk(txd == 1'b1, "R6 break off", txd, 1);

    send(8'hA5);
    wr(8'h14, 8'hff);
    capture(10, got);
    chk(got == 12'h34A, "R7 frame intact under break", got, 12'h34A);
    chk(txd == 1'b0, "R7 low after frame", txd, 0);
    wr(8'h14, 8'h00);

    wr(8'h03, 8'h00);
    wr(8'h0c, 8'h03);
    wr(8'h03, 8'h01);
    chk(in_ready == 1'b1, "R8 value 3 ignored", in_ready, 1);

    wr(8'h03, 8'h00);
    wr(8'h0c, 8'h01);
    wr(8'h03, 8'h01);
    chk(in_ready == 1'b0, "R9 cts_n high blocks", in_ready, 0);
    cts_n = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 cts_n low allows", in_ready, 1);
    send(8'h5A);
    cts_n = 1'b1;
    capture(10, got);
    chk(got == 12'h2B4, "R9 frame completes", got, 12'h2B4);
    chk(in_ready == 1'b0, "R9 blocked after frame", in_ready, 0);

    wr(8'h0c, 8'h00);
    chk(in_ready == 1'b0, "R11 write while tx enabled ignored", in_ready, 0);
    wr(8'h03, 8'h02);
    wr(8'h0c, 8'h00);
    wr(8'h03, 8'h01);
    chk(in_ready == 1'b0, "R11 write while rx enabled ignored", in_ready, 0);

    wr(8'h03, 8'h00);
    wr(8'h0c, 8'h02);
    wr(8'h10, 8'h11);
    wr(8'h11, 8'h13);
    wr(8'h03, 8'h01);
    chk(in_ready == 1'b1, "R10 software mode ignores cts_n", in_ready, 1);
    rx_byte(8'h13);
    chk(in_ready == 1'b0, "R10 stop char pauses", in_ready, 0);
    rx_byte(8'h42);
    chk(in_ready == 1'b0, "R10 other byte no effect", in_ready, 0);
    rx_byte(8'h11);
    chk(in_ready == 1'b1, "R10 resume char", in_ready, 1);
    send(8'hC3);
    rx_byte(8'h13);
    capture(10, got);
    chk(got == 12'h386, "R10 frame completes", got, 12'h386);
    chk(in_ready == 1'b0, "R10 paused after frame", in_ready, 0);
    rx_byte(8'h11);
    chk(in_ready == 1'b1, "R10 resumed", in_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule